// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block sits between the core logic and the device pads and gives a test access port serial control over every pad. Each pad owns three scan bits (a pad-input capture bit, an output-data bit and an active-low output-enable bit) plus two update latches that hold a drive value and an active-low enable. A decoded test mode selects whether the pads follow the core or the update latches. In the two chain modes the scan bits sit between `tdi` and `tdo`. In every other mode a single bypass bit takes their place.

The controller outside the block sequences the strobes. `capture_dr` loads every scan bit in parallel on a rising `tck` edge. `shift_dr` moves the whole path one bit toward `tdo` on each rising edge. `update_dr` copies the scan bits into the update latches on the falling `tck` edge. `tdi` enters at the enable bit of the highest-numbered pad, and `tdo` shows the input-capture bit of pad 0, so pad 0's input is the first bit shifted out.

Each pad cell has three pad sources: core, latch and off. The mode decoder chooses the source with a `unique case`. Functional and sample modes select core, external-test and clamp select latch, and high-impedance selects off. While the test reset is low, core is forced as the source.

Top module: `bsc_chain`

## Requirements
- R1: While `trst_n` is low, every pad shows `core_out`/`core_oe` whatever `mode_sel` is. Reset clears all scan bits, the bypass bit and the drive latches to 0, and sets every enable latch to 1 (disabled). Entering external-test mode straight after reset therefore gives `pad_oe` = 0 and `pad_out` = 0.
- R2: In functional mode (`mode_sel` = 0) and sample mode (`mode_sel` = 1), `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R3: In sample or external-test mode, `capture_dr` loads the scan bits of pad p on a rising edge. Chain bit 3p receives `pad_in[p]`, bit 3p+1 receives `core_out[p]`, and bit 3p+2 receives the inverse of `core_oe[p]`.
- R4: In sample or external-test mode, each rising edge with `shift_dr` (and no `capture_dr`) moves chain bit k+1 into bit k. `tdi` enters bit 3·NUM_PINS−1, and `tdo` shows bit 0.
- R5: In sample or external-test mode, a falling edge with `update_dr` high loads the drive latch of pad p from bit 3p+1 and its enable latch from bit 3p+2. In sample mode this changes no pad.
- R6: In external-test mode (`mode_sel` = 2), `pad_out[p]` equals the drive latch. `pad_oe[p]` is 1 exactly when the active-low enable latch holds 0.
- R7: In clamp mode (`mode_sel` = 3), the pads follow the latches as in R6. Capture, shift and update strobes leave the scan bits and latches unchanged.
- R8: In high-impedance mode (`mode_sel` = 4), every `pad_oe` and `pad_out` bit is 0.
- R9: In every mode other than 1 and 2, the bypass bit sits in the path. `capture_dr` clears it, `shift_dr` loads it from `tdi`, and `tdo` shows it.
- R10: The unused codes 5, 6 and 7 behave exactly as functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| mode_sel | input | 3 | Decoded test mode (0 functional, 1 sample, 2 external-test, 3 clamp, 4 high-impedance) |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Update strobe, acted on at falling `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_out | input | NUM_PINS | Drive values from the core |
| core_oe | input | NUM_PINS | Output enables from the core, active high |
| pad_in | input | NUM_PINS | Values observed at the pads |
| pad_out | output | NUM_PINS | Drive value to each pad buffer |
| pad_oe | output | NUM_PINS | Enable to each pad buffer, active high |

## Verification
The hardest case to reach from the ports is a latch state that can be seen only through the pads, with a chain content that must survive modes which are required to ignore it. The clean example is a clamp-mode strobe burst followed by a sample-mode readout. The stimulus reaches it with a directed sequence: preload in sample mode, check the pads in external-test mode, then strobe in clamp and high-impedance modes and shift the chain out afterwards. After that come long runs of random modes and strobes with occasional resets, all compared against a bench model of the chain, the latches and the bypass bit.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Test mode codes as presented by the instruction decoder
    localparam logic [2:0] MODE_FUNC   = 3'd0;
    localparam logic [2:0] MODE_SAMPLE = 3'd1;
    localparam logic [2:0] MODE_EXTEST = 3'd2;
    localparam logic [2:0] MODE_CLAMP  = 3'd3;
    localparam logic [2:0] MODE_HIGHZ  = 3'd4;

    // Source selected for every pad buffer
    typedef enum logic [1:0] {
        SRC_CORE  = 2'd0,
        SRC_LATCH = 2'd1,
        SRC_OFF   = 2'd2
    } pad_src_e;

endpackage

// File: rtl/bsc_bypass.sv
module bsc_bypass (
    input  logic tck,
    input  logic trst_n,
    input  logic enable,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    output logic byp_q
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (enable && capture_dr) begin
            byp_q <= 1'b0;
        end else if (enable && shift_dr) begin
            byp_q <= tdi;
        end
    end

endmodule

// File: rtl/bsc_pin_cell.sv
module bsc_pin_cell
    import bsc_pkg::*;
(
    input  logic     tck,
    input  logic     trst_n,
    input  logic     chain_sel,
    input  logic     capture_dr,
    input  logic     shift_dr,
    input  logic     update_dr,
    input  pad_src_e pad_src,
    input  logic     core_out,
    input  logic     core_oe,
    input  logic     pad_in,
    input  logic     scan_in,
    output logic     scan_out,
    output logic     pad_out,
    output logic     pad_oe
);

    logic cap_in_q;
    logic cap_dat_q;
    logic cap_oen_q;
    logic upd_dat_q;
    logic upd_oen_q;

    // Scan stage: parallel capture or serial shift on rising tck
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            cap_in_q  <= 1'b0;
            cap_dat_q <= 1'b0;
            cap_oen_q <= 1'b0;
        end else if (chain_sel && capture_dr) begin
            cap_in_q  <= pad_in;
            cap_dat_q <= core_out;
            cap_oen_q <= ~core_oe;
        end else if (chain_sel && shift_dr) begin
            cap_oen_q <= scan_in;
            cap_dat_q <= cap_oen_q;
            cap_in_q  <= cap_dat_q;
        end
    end

    assign scan_out = cap_in_q;

    // Update latches: loaded on falling tck
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_dat_q <= 1'b0;
            upd_oen_q <= 1'b1;
        end else if (chain_sel && update_dr) begin
            upd_dat_q <= cap_dat_q;
            upd_oen_q <= cap_oen_q;
        end
    end

    // Pad driver selection
    always_comb begin
        unique case (pad_src)
            SRC_CORE: begin
                pad_out = core_out;
                pad_oe  = core_oe;
            end
            SRC_LATCH: begin
                pad_out = upd_dat_q;
                pad_oe  = ~upd_oen_q;
            end
            default: begin
                pad_out = 1'b0;
                pad_oe  = 1'b0;
            end
        endcase
    end

    AST_SHIFT_STEP: assert property (@(posedge tck) disable iff (!trst_n)
        (chain_sel && shift_dr && !capture_dr) |=>
        (cap_in_q == $past(cap_dat_q) && cap_oen_q == $past(scan_in))); // R4

    AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        !$past(chain_sel && update_dr) |->
        ($stable(upd_dat_q) && $stable(upd_oen_q))); // R7

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                tck,
    input  logic                trst_n,
    input  logic [2:0]          mode_sel,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    output logic                tdo,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    pad_src_e            pad_src;
    logic                chain_sel;
    logic                byp_q;
    logic [NUM_PINS:0]   link;

    // Mode decode
    always_comb begin
        pad_src   = SRC_CORE;
        chain_sel = 1'b0;
        unique case (mode_sel)
            MODE_SAMPLE: chain_sel = 1'b1;
            MODE_EXTEST: begin
                chain_sel = 1'b1;
                pad_src   = SRC_LATCH;
            end
            MODE_CLAMP:  pad_src = SRC_LATCH;
            MODE_HIGHZ:  pad_src = SRC_OFF;
            default:     pad_src = SRC_CORE;
        endcase
        if (!trst_n) begin
            pad_src = SRC_CORE;
        end
    end

    assign link[NUM_PINS] = tdi;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        bsc_pin_cell u_cell (
            .tck        (tck),
            .trst_n     (trst_n),
            .chain_sel  (chain_sel),
            .capture_dr (capture_dr),
            .shift_dr   (shift_dr),
            .update_dr  (update_dr),
            .pad_src    (pad_src),
            .core_out   (core_out[p]),
            .core_oe    (core_oe[p]),
            .pad_in     (pad_in[p]),
            .scan_in    (link[p+1]),
            .scan_out   (link[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p])
        );
    end

    bsc_bypass u_bypass (
        .tck        (tck),
        .trst_n     (trst_n),
        .enable     (!chain_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .byp_q      (byp_q)
    );

    assign tdo = chain_sel ? link[0] : byp_q;

    AST_HIGHZ_FLOAT: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == MODE_HIGHZ) |-> (pad_oe == '0)); // R8

    AST_FUNC_PASS: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == MODE_FUNC) |-> (pad_out == core_out && pad_oe == core_oe)); // R2

    AST_BYPASS_PATH: assert property (@(posedge tck) disable iff (!trst_n)
        (!chain_sel && shift_dr && !capture_dr) ##1 !chain_sel |->
        (tdo == $past(tdi))); // R9

    AST_RESET_CORE: assert property (@(negedge tck)
        !trst_n |-> (pad_out == core_out && pad_oe == core_oe)); // R1

endmodule

// File: tb/bsc_chain_tb.sv
module bsc_chain_tb;

    localparam int N = 8;
    localparam int L = 3 * N;

    logic         tck = 1'b0;
    logic         trst_n;
    logic [2:0]   mode_sel;
    logic         capture_dr, shift_dr, update_dr, tdi;
    logic         tdo;
    logic [N-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    logic [L-1:0] sr_m;
    logic [N-1:0] lat_dat_m, lat_oen_m;
    logic         byp_m;

    always #4 tck = ~tck;

    bsc_chain #(.NUM_PINS(N)) u_dut (
        .tck(tck), .trst_n(trst_n), .mode_sel(mode_sel),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .core_out(core_out), .core_oe(core_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic chain_mode(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd2);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        sr_m      = '0;
        byp_m     = 1'b0;
        lat_dat_m = '0;
        lat_oen_m = '1;
    endtask

    task automatic check_pins();
        logic [N-1:0] eo, ee;
        string tag;
        if (!trst_n) begin
            eo = core_out; ee = core_oe; tag = "R1";
        end else begin
            case (mode_sel)
                3'd0, 3'd1: begin eo = core_out; ee = core_oe; tag = "R2"; end
                3'd2: begin eo = lat_dat_m; ee = ~lat_oen_m; tag = "R6"; end
                3'd3: begin eo = lat_dat_m; ee = ~lat_oen_m; tag = "R7"; end
                3'd4: begin eo = '0; ee = '0; tag = "R8"; end
                default: begin eo = core_out; ee = core_oe; tag = "R10"; end
            endcase
        end
        check(tag, "pad_out", pad_out, eo);
        check(tag, "pad_oe", pad_oe, ee);
    endtask

    // One tck cycle; entered and left just after a falling edge
    task automatic cyc(input logic [2:0] m, input logic c, input logic s,
                       input logic u, input logic ti);
        logic sel;
        mode_sel = m; capture_dr = c; shift_dr = s; update_dr = u; tdi = ti;
        core_out = N'($urandom); core_oe = N'($urandom); pad_in = N'($urandom);
        if (!trst_n) model_reset();
        sel = chain_mode(m);
        #1;
        check_pins();
        check(sel ? "R4" : "R9", "tdo", N'(tdo), N'(sel ? sr_m[0] : byp_m));
        @(posedge tck);
        if (trst_n) begin
            if (sel && c) begin
                for (int p = 0; p < N; p++) begin
                    sr_m[3*p]   = pad_in[p];
                    sr_m[3*p+1] = core_out[p];
                    sr_m[3*p+2] = ~core_oe[p];
                end
            end else if (sel && s) begin
                sr_m = {ti, sr_m[L-1:1]};
            end else if (!sel && c) begin
                byp_m = 1'b0;
            end else if (!sel && s) begin
                byp_m = ti;
            end
        end
        @(negedge tck);
        if (trst_n && sel && u) begin
            for (int p = 0; p < N; p++) begin
                lat_dat_m[p] = sr_m[3*p+1];
                lat_oen_m[p] = sr_m[3*p+2];
            end
        end
        #1;
        check_pins();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        trst_n = 1'b0; mode_sel = 3'd2;
        capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
        core_out = '0; core_oe = '0; pad_in = '0;
        model_reset();
        @(negedge tck); #1;

        // R1: reset forces core path even in external-test mode
        repeat (3) cyc(3'd2, 1, 1, 1, 1);
        trst_n = 1'b1;
        // R1: latches start disabled
        cyc(3'd2, 0, 0, 0, 0);
        check("R1", "extest oe after reset", pad_oe, '0);

        // R3 R4: sample capture then full readout with a walking pattern
        cyc(3'd1, 1, 0, 0, 0);
        for (int i = 0; i < L; i++) cyc(3'd1, 0, 1, 0, (i % 3) == 0);
        // R5: preload does not disturb pads in sample mode
        cyc(3'd1, 0, 0, 1, 0);
        // R6: external-test drives preloaded values
        cyc(3'd2, 0, 0, 0, 0);
        check("R6", "extest oe from preload", pad_oe, ~lat_oen_m);

        // R7: clamp ignores strobes; read chain back afterwards
        cyc(3'd3, 1, 0, 0, 1);
        repeat (5) cyc(3'd3, 0, 1, 0, 1);
        cyc(3'd3, 0, 0, 1, 0);
        // R8 R9: high-impedance with bypass shifting
        cyc(3'd4, 1, 0, 0, 1);
        repeat (4) cyc(3'd4, 0, 1, 0, 1);
        // R10: unused code behaves as functional
        cyc(3'd6, 0, 1, 0, 0);
        cyc(3'd7, 1, 0, 1, 1);
        for (int i = 0; i < L; i++) cyc(3'd1, 0, 1, 0, 0);

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 4;
            if (($urandom % 200) == 0) trst_n = 1'b0;
            else trst_n = 1'b1;
            cyc(3'($urandom % 8), r == 0, r == 1, r == 2, 1'($urandom));
        end
        trst_n = 1'b1;
        cyc(3'd0, 0, 0, 0, 0);
        finish_run();
    end

endmodule